// File: doc/BRIEF.md
# Settable 12-Hour Time-of-Day Keeper

This block keeps a 12-hour time of day: an AM/PM flag, an hour from 1 to 12, and minutes and seconds, all held as BCD digits. It runs from a 100 Hz clock, so one clock cycle is one tick. Two key levels, SET and INC, are each turned into a single-tick pulse by a two-flop rising-edge detector. A six-state mode machine steps on SET pulses. From an initial state it moves through four editing states (AM/PM, hour, minute tens, minute ones) and then into the run state. In each editing state, INC changes only the field being edited, and each field wraps by its own rule.

The block drives the BCD time fields, one flag per mode state, a flag that is high while a field is being edited, and a blink signal. The blink signal alternates every half second while the block sits in the initial state or in an editing state. In the run state it stays high. A downstream display uses it to blank the field being edited. Time advances only in the run state. Entering the run state clears the seconds and restarts the one-second divider, so the clock starts at an exact minute.

All pins are plain control and status levels sampled on the tick clock. There is no data stream and no handshake.

Top module: `clock12_setter`

## Requirements
- R1: After reset the state flag for S0 is set (mode_oh = 6'b000001), edit_mode is 0, the time is AM 12:00:00 (is_pm = 0) and blink_on is 1.
- R2: The mode flags are one-hot, with bit i meaning state Si (S0 initial, S1 AM/PM edit, S2 hour edit, S3 minute-tens edit, S4 minute-ones edit, S5 run). A SET pulse moves S0→S1→S2→S3→S4→S5, and from S5 back to S1. With no SET pulse the state holds. edit_mode is 1 exactly in S1 to S4.
- R3: In S1 an INC pulse toggles is_pm (1 means PM).
- R4: In S2 an INC pulse steps the hour 12→1→2→…→9→10→11→12, leaving is_pm unchanged. The hour digits are always a legal hour from 1 to 12.
- R5: In S3 an INC pulse steps the minute-tens digit 0 to 5, then wraps to 0.
- R6: In S4 an INC pulse steps the minute-ones digit 0 to 9, then wraps to 0.
- R7: An INC pulse in S0 or in S5 leaves AM/PM, hour and minutes unchanged.
- R8: The time is frozen outside S5. Entering S5 clears the seconds to 00 and restarts the divider, so the first seconds step comes 100 ticks after the entry tick and each further step 100 ticks later.
- R9: In S5, 11:59:59 advances to 12:00:00 and toggles is_pm. 12:59:59 advances to 01:00:00 and leaves is_pm unchanged.
- R10: In S0 to S4, blink_on inverts every 50 ticks, starting high after reset. In S5, blink_on is 1.
- R11: In S1 to S4, a SET or INC pulse sets blink_on to 1 and restarts the 50-tick half period.
- R12: A key held high for many ticks produces exactly one pulse, so one press gives one action.
- R13: When SET and INC pulse in the same tick, INC edits the field of the state being left and the state advances. In S4 this also clears the seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 Hz tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_key | input | 1 | SET key level, active high |
| inc_key | input | 1 | INC key level, active high |
| is_pm | output | 1 | 0 = AM, 1 = PM |
| hour_tens | output | 1 | Hour tens digit |
| hour_ones | output | 4 | Hour ones digit (BCD) |
| min_tens | output | 3 | Minute tens digit |
| min_ones | output | 4 | Minute ones digit (BCD) |
| sec_tens | output | 3 | Second tens digit |
| sec_ones | output | 4 | Second ones digit (BCD) |
| mode_oh | output | 6 | One-hot state flags, bit i = Si |
| edit_mode | output | 1 | High in the four editing states |
| blink_on | output | 1 | Display-enable for the edited field |

## Verification
The case that needs most care is a SET pulse and an INC pulse in the same tick. Both keys are driven high on the same edge, so their pulses coincide. In the hour-edit state the bench then expects the hour to step and the state to move to minute-tens editing. In the minute-ones state it expects the ones digit to step and the machine to enter run, with the seconds cleared. A second overlap is a key pulse landing while the blink is off. The bench waits until blink_on is low, presses INC, and then checks that blink_on is high again and stays high for a full fresh half period.

// File: rtl/clk12_pkg.sv
package clk12_pkg;

  typedef enum logic [2:0] {
    MD_IDLE    = 3'd0,
    MD_EDIT_AP = 3'd1,
    MD_EDIT_HR = 3'd2,
    MD_EDIT_MT = 3'd3,
    MD_EDIT_MO = 3'd4,
    MD_RUN     = 3'd5
  } mode_e;

  localparam int NUM_MODES = 6;
  localparam int NUM_KEYS  = 2;

  // hour as {tens, ones}: 12 -> 01 -> ... -> 09 -> 10 -> 11 -> 12
  function automatic logic [4:0] hour_next(input logic [4:0] h);
    if (h == 5'h12)
      return 5'h01;
    else if (h[3:0] == 4'd9)
      return 5'h10;
    else
      return {h[4], h[3:0] + 4'd1};
  endfunction

  function automatic logic [3:0] ones_next(input logic [3:0] d);
    return (d >= 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  function automatic logic [2:0] tens_next(input logic [2:0] d);
    return (d >= 3'd5) ? 3'd0 : d + 3'd1;
  endfunction

endpackage

// File: rtl/key_edge.sv
module key_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic q_now, q_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_now <= 1'b0;
      q_old <= 1'b0;
    end else begin
      q_now <= level;
      q_old <= q_now;
    end
  end

  assign pulse = q_now & ~q_old;

  AST_ONE_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R12

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import clk12_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_p,
  output mode_e                mode,
  output logic [NUM_MODES-1:0] mode_oh,
  output logic                 edit_mode
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (set_p) begin
      case (mode_q)
        MD_IDLE:    mode_d = MD_EDIT_AP;
        MD_EDIT_AP: mode_d = MD_EDIT_HR;
        MD_EDIT_HR: mode_d = MD_EDIT_MT;
        MD_EDIT_MT: mode_d = MD_EDIT_MO;
        MD_EDIT_MO: mode_d = MD_RUN;
        MD_RUN:     mode_d = MD_EDIT_AP;
        default:    mode_d = MD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_IDLE;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_flag
    assign mode_oh[i] = (mode_q == mode_e'(i));
  end

  assign edit_mode = (mode_q == MD_EDIT_AP) || (mode_q == MD_EDIT_HR) ||
                     (mode_q == MD_EDIT_MT) || (mode_q == MD_EDIT_MO);

  AST_ENTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (set_p && mode_q == MD_EDIT_MO) |=> mode_q == MD_RUN); // R2
  AST_RUN_TO_AP: assert property (@(posedge clk) disable iff (!rst_n)
    (set_p && mode_q == MD_RUN) |=> mode_q == MD_EDIT_AP); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !set_p |=> $stable(mode_q)); // R2

endmodule

// File: rtl/time_keeper.sv
module time_keeper
  import clk12_pkg::*;
#(
  parameter int TICKS_PER_SEC = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  mode_e      mode,
  input  logic       set_p,
  input  logic       inc_p,
  output logic       is_pm,
  output logic [4:0] hour_bcd,
  output logic [2:0] min_tens,
  output logic [3:0] min_ones,
  output logic [2:0] sec_tens,
  output logic [3:0] sec_ones
);
  localparam int SUB_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);

  logic [SUB_W-1:0] sub_q;
  logic             pm_q, pm_d;
  logic [4:0]       hr_q, hr_d;
  logic [2:0]       mt_q, mt_d, st_q, st_d;
  logic [3:0]       mo_q, mo_d, so_q, so_d;
  logic             run, enter_run, sec_tick;

  assign run       = (mode == MD_RUN);
  assign enter_run = set_p && (mode == MD_EDIT_MO);
  assign sec_tick  = run && (sub_q == SUB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sub_q <= '0;
    else if (enter_run)  sub_q <= '0;
    else if (run)        sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
  end

  always_comb begin
    pm_d = pm_q; hr_d = hr_q; mt_d = mt_q; mo_d = mo_q; st_d = st_q; so_d = so_q;
    case (mode)
      MD_EDIT_AP: if (inc_p) pm_d = ~pm_q;
      MD_EDIT_HR: if (inc_p) hr_d = hour_next(hr_q);
      MD_EDIT_MT: if (inc_p) mt_d = tens_next(mt_q);
      MD_EDIT_MO: begin
        if (inc_p) mo_d = ones_next(mo_q);
        if (set_p) begin
          st_d = '0;
          so_d = '0;
        end
      end
      MD_RUN: if (sec_tick) begin
        so_d = ones_next(so_q);
        if (so_q == 4'd9) begin
          st_d = tens_next(st_q);
          if (st_q == 3'd5) begin
            mo_d = ones_next(mo_q);
            if (mo_q == 4'd9) begin
              mt_d = tens_next(mt_q);
              if (mt_q == 3'd5) begin
                hr_d = hour_next(hr_q);
                if (hr_q == 5'h11) pm_d = ~pm_q;
              end
            end
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q <= 1'b0;
      hr_q <= 5'h12;
      mt_q <= '0;
      mo_q <= '0;
      st_q <= '0;
      so_q <= '0;
    end else begin
      pm_q <= pm_d;
      hr_q <= hr_d;
      mt_q <= mt_d;
      mo_q <= mo_d;
      st_q <= st_d;
      so_q <= so_d;
    end
  end

  assign is_pm    = pm_q;
  assign hour_bcd = hr_q;
  assign min_tens = mt_q;
  assign min_ones = mo_q;
  assign sec_tens = st_q;
  assign sec_ones = so_q;

  AST_HOUR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_q[4] == 1'b0 && hr_q[3:0] >= 4'd1 && hr_q[3:0] <= 4'd9) ||
    (hr_q[4] == 1'b1 && hr_q[3:0] <= 4'd2)); // R4
  AST_MIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mt_q <= 3'd5 && mo_q <= 4'd9); // R5
  AST_FROZEN_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_RUN && !inc_p) |=> $stable({pm_q, hr_q, mt_q, mo_q})); // R8
  AST_FROZEN_SECS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_RUN && !enter_run) |=> $stable({st_q, so_q})); // R8
  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    enter_run |=> (st_q == 3'd0 && so_q == 4'd0)); // R8
  AST_IDLE_INC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_IDLE) |=> $stable({pm_q, hr_q, mt_q, mo_q})); // R7
  AST_NOON_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && hr_q == 5'h11 && mt_q == 3'd5 && mo_q == 4'd9 &&
     st_q == 3'd5 && so_q == 4'd9) |=> (pm_q != $past(pm_q))); // R9

endmodule

// File: rtl/blink_gen.sv
module blink_gen #(
  parameter int HALF_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edit_mode,
  input  logic run,
  input  logic set_p,
  input  logic inc_p,
  output logic blink_on
);
  localparam int CNT_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      on_q  <= 1'b1;
    end else if (run || (edit_mode && (set_p || inc_p))) begin
      cnt_q <= '0;
      on_q  <= 1'b1;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      on_q  <= ~on_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign blink_on = on_q;

  AST_KEY_FORCES_SHOW: assert property (@(posedge clk) disable iff (!rst_n)
    (edit_mode && (set_p || inc_p)) |=> blink_on); // R11
  AST_RUN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> blink_on); // R10

endmodule

// File: rtl/clock12_setter.sv
module clock12_setter
  import clk12_pkg::*;
#(
  parameter int TICKS_PER_SEC = 100,
  parameter int HALF_TICKS    = TICKS_PER_SEC / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_key,
  input  logic       inc_key,
  output logic       is_pm,
  output logic       hour_tens,
  output logic [3:0] hour_ones,
  output logic [2:0] min_tens,
  output logic [3:0] min_ones,
  output logic [2:0] sec_tens,
  output logic [3:0] sec_ones,
  output logic [5:0] mode_oh,
  output logic       edit_mode,
  output logic       blink_on
);
  logic [NUM_KEYS-1:0] key_lvl, key_pulse;
  logic                set_p, inc_p;
  mode_e               mode;
  logic [4:0]          hour_bcd;

  assign key_lvl = {inc_key, set_key};

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    key_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (key_lvl[k]),
      .pulse (key_pulse[k])
    );
  end

  assign set_p = key_pulse[0];
  assign inc_p = key_pulse[1];

  mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_p     (set_p),
    .mode      (mode),
    .mode_oh   (mode_oh),
    .edit_mode (edit_mode)
  );

  time_keeper #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .set_p    (set_p),
    .inc_p    (inc_p),
    .is_pm    (is_pm),
    .hour_bcd (hour_bcd),
    .min_tens (min_tens),
    .min_ones (min_ones),
    .sec_tens (sec_tens),
    .sec_ones (sec_ones)
  );

  assign hour_tens = hour_bcd[4];
  assign hour_ones = hour_bcd[3:0];

  blink_gen #(.HALF_TICKS(HALF_TICKS)) u_blink (
    .clk       (clk),
    .rst_n     (rst_n),
    .edit_mode (edit_mode),
    .run       (mode == MD_RUN),
    .set_p     (set_p),
    .inc_p     (inc_p),
    .blink_on  (blink_on)
  );

  AST_ONEHOT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_oh) && (mode_oh != 6'd0)); // R2

endmodule

// File: tb/clock12_setter_test.sv
module clock12_setter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       set_key = 1'b0;
  logic       inc_key = 1'b0;
  logic       is_pm, hour_tens, edit_mode, blink_on;
  logic [3:0] hour_ones, min_ones, sec_ones;
  logic [2:0] min_tens, sec_tens;
  logic [5:0] mode_oh;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  int e_run = 0;

  clock12_setter uut (
    .clk(clk), .rst_n(rst_n), .set_key(set_key), .inc_key(inc_key),
    .is_pm(is_pm), .hour_tens(hour_tens), .hour_ones(hour_ones),
    .min_tens(min_tens), .min_ones(min_ones), .sec_tens(sec_tens),
    .sec_ones(sec_ones), .mode_oh(mode_oh), .edit_mode(edit_mode),
    .blink_on(blink_on)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic chk_time(input string req, input int pm, input int hr,
                          input int mn, input int sc);
    chk({req, " pm"},   is_pm, pm);
    chk({req, " hour"}, hour_tens * 10 + hour_ones, hr);
    chk({req, " min"},  min_tens * 10 + min_ones, mn);
    chk({req, " sec"},  sec_tens * 10 + sec_ones, sc);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // returns the cycle count of the edge at which the pulse acts
  task automatic press(input bit s, input bit i, input int hold, output int acted);
    @(negedge clk);
    acted = cyc + 2;
    set_key = s;
    inc_key = i;
    repeat (hold) @(negedge clk);
    set_key = 0;
    inc_key = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic tap_set();
    int a;
    press(1, 0, 3, a);
  endtask

  task automatic tap_inc(input int n);
    int a;
    for (int k = 0; k < n; k++) press(0, 1, 3, a);
  endtask

  task automatic t_reset();
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    c0 = cyc;
    chk("R1 mode", mode_oh, 6'b000001);
    chk("R1 edit_mode", edit_mode, 0);
    chk("R1 blink", blink_on, 1);
    chk_time("R1", 0, 12, 0, 0);
    wait_until(c0 + 25);
    chk("R10 blink on phase", blink_on, 1);
    wait_until(c0 + 75);
    chk("R10 blink off phase", blink_on, 0);
    wait_until(c0 + 125);
    chk("R10 blink on again", blink_on, 1);
  endtask

  task automatic t_idle_inc();
    tap_inc(2);
    chk_time("R7 idle inc", 0, 12, 0, 0);
    chk("R7 still S0", mode_oh, 6'b000001);
  endtask

  task automatic t_ampm();
    tap_set();
    chk("R2 S1", mode_oh, 6'b000010);
    chk("R2 edit_mode S1", edit_mode, 1);
    tap_inc(1);
    chk("R3 pm toggle", is_pm, 1);
    tap_inc(1);
    chk("R3 pm back", is_pm, 0);
  endtask

  task automatic t_hour();
    int a;
    tap_set();
    chk("R2 S2", mode_oh, 6'b000100);
    tap_inc(1);
    chk("R4 12 wraps to 1", hour_tens * 10 + hour_ones, 1);
    chk("R4 pm untouched", is_pm, 0);
    tap_inc(9);
    chk("R4 9 to 10", hour_tens * 10 + hour_ones, 10);
    // blink forced on by a key
    for (int k = 0; k < 200 && blink_on; k++) @(negedge clk);
    chk("R11 blink low before key", blink_on, 0);
    press(0, 1, 3, a);
    chk("R11 forced show", blink_on, 1);
    chk("R4 10 to 11", hour_tens * 10 + hour_ones, 11);
    wait_until(a + 48);
    chk("R11 half period restarted", blink_on, 1);
    // same tick SET + INC in S2
    press(1, 1, 3, a);
    chk("R13 hour stepped", hour_tens * 10 + hour_ones, 12);
    chk("R13 moved to S3", mode_oh, 6'b001000);
    tap_inc(1); // back to 11 via wrap? no: S3 now, edits minute tens
    chk("R5 tens 0 to 1", min_tens, 1);
  endtask

  task automatic t_minutes_to_run();
    int a;
    tap_inc(4);
    chk("R5 tens at 5", min_tens, 5);
    tap_inc(1);
    chk("R5 tens wraps", min_tens, 0);
    tap_inc(5);
    tap_set();
    chk("R2 S4", mode_oh, 6'b010000);
    tap_inc(9);
    chk("R6 ones at 9", min_ones, 9);
    tap_inc(1);
    chk("R6 ones wraps", min_ones, 0);
    tap_inc(8);
    press(1, 1, 3, a);
    e_run = a;
    chk("R13 ones stepped", min_ones, 9);
    chk("R13 entered S5", mode_oh, 6'b100000);
    chk("R2 edit_mode off in S5", edit_mode, 0);
    chk("R10 blink steady in S5", blink_on, 1);
  endtask

  // hour currently 12 after R13 step; set it to 11 by walking around: done in t_rollover
  task automatic t_run_checks();
    chk_time("R8 start of run", 0, 12, 59, 0);
    tap_inc(2);
    wait_until(e_run + 90);
    chk("R8 no step before 100 ticks", sec_ones, 0);
    wait_until(e_run + 110);
    chk_time("R7 run inc ignored / R8 one second", 0, 12, 59, 1);
    wait_until(e_run + 5950);
    chk_time("R9 before 1 o'clock", 0, 12, 59, 59);
    wait_until(e_run + 6050);
    chk_time("R9 12:59:59 to 1:00:00", 0, 1, 0, 0);
  endtask

  task automatic t_noon();
    int a;
    wait_until(e_run + 6350);
    chk("R8 sec before stop", sec_ones, 3);
    press(1, 0, 20, a); // long hold: one step only
    chk("R12 held SET gives one step", mode_oh, 6'b000010);
    tap_set();
    tap_inc(10); // hour 1 -> 11
    chk("R4 hour 11", hour_tens * 10 + hour_ones, 11);
    tap_set();
    tap_inc(5);
    tap_set();
    tap_inc(9);
    chk_time("R8 frozen while editing", 0, 11, 59, 3);
    press(1, 0, 3, a);
    e_run = a;
    chk("R8 seconds cleared on entry", sec_tens * 10 + sec_ones, 0);
    chk("R10 blink S5", blink_on, 1);
    wait_until(e_run + 5950);
    chk_time("R9 before noon", 0, 11, 59, 59);
    wait_until(e_run + 6050);
    chk_time("R9 11:59:59 to 12:00:00", 1, 12, 0, 0);
  endtask

  initial begin
    t_reset();
    t_idle_inc();
    t_ampm();
    t_hour();
    t_minutes_to_run();
    t_run_checks();
    t_noon();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule